// File: doc/BRIEF.md
# Multicycle Processor Control Sequencer

This block is the hardwired control unit of a multicycle 32-bit load/store processor. It holds a 4-bit state register and moves through a fixed sequence of states for each instruction. From each state it drives the select and write-enable lines of a shared-ALU datapath. The datapath, the memory and the register file live outside the block. The block reads only the opcode field of the instruction register, the ALU zero flag and the ALU overflow flag.

Every instruction starts with a fetch state and then a decode state. The decode state dispatches on the opcode. The execute, memory and write-back states that follow depend on the instruction class.

Two extra states handle exceptions, one for an unrecognised opcode and one for arithmetic overflow in a register-register operation. Each of them makes the ALU compute PC minus 4 and stores that value in the exception PC register. It also writes a cause bit and loads the PC from a fixed handler-address input of the PC multiplexer.

Top module: `mc_ctrl_fsm`

## Requirements
- R1: While `rst` is high at a rising edge, the next state is fetch. While `rst` is high, every output is 0, so no write enable is active.
- R2: The fetch state drives `mem_rd=1`, `addr_sel_alu=0`, `ir_we=1`, `alu_a_sel=0`, `alu_b_sel=01` (constant 4), `alu_op=00` (add), `pc_we=1` and `pc_src=00` (ALU result). The state after fetch is always decode.
- R3: The decode state drives `alu_a_sel=0`, `alu_b_sel=11` (immediate shifted left by 2) and `alu_op=00`, and all write enables are 0. It dispatches on the opcode: 100011 (load) and 101011 (store) go to address calculation, 000000 to register execute, 000100 to branch and 000010 to jump.
- R4: A load passes through address calculation (`alu_a_sel=1`, `alu_b_sel=10`, `alu_op=00`), then memory read (`mem_rd=1`, `addr_sel_alu=1`), then write-back (`rf_we=1`, `wb_sel_mem=1`, `dst_sel_rd=0`).
- R5: A store passes through address calculation and then memory write (`mem_wr=1`, `addr_sel_alu=1`).
- R6: A register-register instruction passes through execute (`alu_a_sel=1`, `alu_b_sel=00`, `alu_op=10`, function field) and then write-back (`rf_we=1`, `dst_sel_rd=1`, `wb_sel_mem=0`).
- R7: The branch state drives `alu_a_sel=1`, `alu_b_sel=00`, `alu_op=01` (subtract), `pc_we_cond=1` and `pc_src=01` (ALU output register). `pc_load` equals `alu_zero` in this state, and `pc_load` equals `pc_we` in every other state.
- R8: The jump state drives `pc_we=1` and `pc_src=10` (jump target).
- R9: Any other opcode in decode goes to the undefined-opcode exception state. That state drives `alu_a_sel=0`, `alu_b_sel=01`, `alu_op=01` (PC minus 4), `epc_we=1`, `cause_we=1`, `cause_val=0`, `pc_we=1` and `pc_src=11` (handler address 0x80000080).
- R10: `alu_ovf` is sampled only in register execute. If it is set there, the next state is the overflow exception state, which drives the same outputs as R9 but with `cause_val=1`. The register-file write-back is skipped. `alu_ovf` has no effect in any other state.
- R11: After the load write-back, store memory, register write-back, branch, jump and both exception states, the next state is fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| opcode | input | 6 | Opcode field of the instruction register |
| alu_zero | input | 1 | ALU result equals zero |
| alu_ovf | input | 1 | ALU signed overflow |
| dst_sel_rd | output | 1 | Destination register from rd (1) or rt (0) |
| rf_we | output | 1 | Register file write enable |
| alu_a_sel | output | 1 | ALU operand A: register A (1) or PC (0) |
| alu_b_sel | output | 2 | ALU operand B select |
| alu_op | output | 2 | ALU operation class |
| mem_rd | output | 1 | Memory read |
| mem_wr | output | 1 | Memory write |
| wb_sel_mem | output | 1 | Register write data from memory data register (1) or ALU output register (0) |
| addr_sel_alu | output | 1 | Memory address from ALU output register (1) or PC (0) |
| ir_we | output | 1 | Instruction register write enable |
| pc_we | output | 1 | Unconditional PC write |
| pc_we_cond | output | 1 | PC write when zero is set |
| pc_src | output | 2 | PC source select |
| pc_load | output | 1 | Combined PC load enable |
| epc_we | output | 1 | Exception PC write enable |
| cause_we | output | 1 | Cause register write enable |
| cause_val | output | 1 | Cause code to write |

## Verification
The bench runs every instruction class with `alu_zero` and `alu_ovf` held high in states where they must be ignored. A sequencer that sampled overflow outside register execute would reach the overflow exception from a load or a branch. One that gated the PC with zero outside the branch state would stall fetch. It takes a branch both taken and not taken, so a `pc_load` that ignored zero would move the PC on a failing compare. It decodes an unlisted opcode, which a dispatch with a default arm pointing at a valid path would execute instead of trapping. It pulses reset in the middle of a load, where any write enable leaking through reset would corrupt the register file, and a wrong restart state would skip fetch.

// File: rtl/mc_ctrl_pkg.sv
package mc_ctrl_pkg;
    localparam int OP_W = 6;
    localparam int ST_W = 4;

    localparam logic [OP_W-1:0] OP_RR  = 6'b000000;
    localparam logic [OP_W-1:0] OP_LD  = 6'b100011;
    localparam logic [OP_W-1:0] OP_ST  = 6'b101011;
    localparam logic [OP_W-1:0] OP_BEQ = 6'b000100;
    localparam logic [OP_W-1:0] OP_JMP = 6'b000010;

    typedef enum logic [ST_W-1:0] {
        S_FETCH   = 4'd0,
        S_DECODE  = 4'd1,
        S_ADDR    = 4'd2,
        S_LD_MEM  = 4'd3,
        S_LD_WB   = 4'd4,
        S_ST_MEM  = 4'd5,
        S_RR_EX   = 4'd6,
        S_RR_WB   = 4'd7,
        S_BRANCH  = 4'd8,
        S_JUMP    = 4'd9,
        S_EXC_UND = 4'd10,
        S_EXC_OVF = 4'd11
    } state_e;

    typedef struct packed {
        logic       dst_rd;
        logic       rf_we;
        logic       a_sel;
        logic [1:0] b_sel;
        logic [1:0] alu_op;
        logic       mem_rd;
        logic       mem_wr;
        logic       wb_mem;
        logic       addr_alu;
        logic       ir_we;
        logic       pc_we;
        logic       pc_we_cond;
        logic [1:0] pc_src;
        logic       epc_we;
        logic       cause_we;
        logic       cause_val;
    } ctrl_t;

    typedef struct packed {
        state_e state;
    } fsm_t;
endpackage

// File: rtl/mc_seq_next.sv
module mc_seq_next
    import mc_ctrl_pkg::*;
(
    input  state_e          cur,
    input  logic [OP_W-1:0] opcode,
    input  logic            alu_ovf,
    output state_e          nxt
);
    always_comb begin
        nxt = S_FETCH;
        unique case (cur)
            S_FETCH:  nxt = S_DECODE;
            S_DECODE: begin
                if (opcode == OP_LD || opcode == OP_ST) nxt = S_ADDR;
                else if (opcode == OP_RR)               nxt = S_RR_EX;
                else if (opcode == OP_BEQ)              nxt = S_BRANCH;
                else if (opcode == OP_JMP)              nxt = S_JUMP;
                else                                    nxt = S_EXC_UND;
            end
            S_ADDR:   nxt = (opcode == OP_LD) ? S_LD_MEM : S_ST_MEM;
            S_LD_MEM: nxt = S_LD_WB;
            S_RR_EX:  nxt = alu_ovf ? S_EXC_OVF : S_RR_WB;
            default:  nxt = S_FETCH;
        endcase
    end
endmodule

// File: rtl/mc_ctrl_rom.sv
module mc_ctrl_rom
    import mc_ctrl_pkg::*;
(
    input  state_e cur,
    output ctrl_t  ctl
);
    always_comb begin
        ctl = '0;
        unique case (cur)
            S_FETCH: begin
                ctl.mem_rd = 1'b1;
                ctl.ir_we  = 1'b1;
                ctl.b_sel  = 2'b01;
                ctl.pc_we  = 1'b1;
            end
            S_DECODE: ctl.b_sel = 2'b11;
            S_ADDR: begin
                ctl.a_sel = 1'b1;
                ctl.b_sel = 2'b10;
            end
            S_LD_MEM: begin
                ctl.mem_rd   = 1'b1;
                ctl.addr_alu = 1'b1;
            end
            S_LD_WB: begin
                ctl.rf_we  = 1'b1;
                ctl.wb_mem = 1'b1;
            end
            S_ST_MEM: begin
                ctl.mem_wr   = 1'b1;
                ctl.addr_alu = 1'b1;
            end
            S_RR_EX: begin
                ctl.a_sel  = 1'b1;
                ctl.alu_op = 2'b10;
            end
            S_RR_WB: begin
                ctl.rf_we  = 1'b1;
                ctl.dst_rd = 1'b1;
            end
            S_BRANCH: begin
                ctl.a_sel      = 1'b1;
                ctl.alu_op     = 2'b01;
                ctl.pc_we_cond = 1'b1;
                ctl.pc_src     = 2'b01;
            end
            S_JUMP: begin
                ctl.pc_we  = 1'b1;
                ctl.pc_src = 2'b10;
            end
            S_EXC_UND, S_EXC_OVF: begin
                ctl.b_sel     = 2'b01;
                ctl.alu_op    = 2'b01;
                ctl.epc_we    = 1'b1;
                ctl.cause_we  = 1'b1;
                ctl.cause_val = (cur == S_EXC_OVF);
                ctl.pc_we     = 1'b1;
                ctl.pc_src    = 2'b11;
            end
            default: ctl = '0;
        endcase
    end
endmodule

// File: rtl/mc_ctrl_fsm.sv
module mc_ctrl_fsm
    import mc_ctrl_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [OP_W-1:0] opcode,
    input  logic            alu_zero,
    input  logic            alu_ovf,
    output logic            dst_sel_rd,
    output logic            rf_we,
    output logic            alu_a_sel,
    output logic [1:0]      alu_b_sel,
    output logic [1:0]      alu_op,
    output logic            mem_rd,
    output logic            mem_wr,
    output logic            wb_sel_mem,
    output logic            addr_sel_alu,
    output logic            ir_we,
    output logic            pc_we,
    output logic            pc_we_cond,
    output logic [1:0]      pc_src,
    output logic            pc_load,
    output logic            epc_we,
    output logic            cause_we,
    output logic            cause_val
);
    fsm_t   fsm_d, fsm_q;
    state_e seq_nxt;
    ctrl_t  rom_ctl, ctl;

    mc_seq_next u_next (
        .cur     (fsm_q.state),
        .opcode  (opcode),
        .alu_ovf (alu_ovf),
        .nxt     (seq_nxt)
    );

    mc_ctrl_rom u_rom (
        .cur (fsm_q.state),
        .ctl (rom_ctl)
    );

    always_comb begin
        fsm_d       = fsm_q;
        fsm_d.state = rst ? S_FETCH : seq_nxt;
        ctl         = rst ? '0 : rom_ctl;
    end

    always_ff @(posedge clk) begin
        fsm_q <= fsm_d;
    end

    assign dst_sel_rd   = ctl.dst_rd;
    assign rf_we        = ctl.rf_we;
    assign alu_a_sel    = ctl.a_sel;
    assign alu_b_sel    = ctl.b_sel;
    assign alu_op       = ctl.alu_op;
    assign mem_rd       = ctl.mem_rd;
    assign mem_wr       = ctl.mem_wr;
    assign wb_sel_mem   = ctl.wb_mem;
    assign addr_sel_alu = ctl.addr_alu;
    assign ir_we        = ctl.ir_we;
    assign pc_we        = ctl.pc_we;
    assign pc_we_cond   = ctl.pc_we_cond;
    assign pc_src       = ctl.pc_src;
    assign pc_load      = ctl.pc_we | (ctl.pc_we_cond & alu_zero);
    assign epc_we       = ctl.epc_we;
    assign cause_we     = ctl.cause_we;
    assign cause_val    = ctl.cause_val;
endmodule

// File: rtl/mc_ctrl_fsm_chk.sv
module mc_ctrl_fsm_chk (
    input logic       clk,
    input logic       rst,
    input logic       alu_zero,
    input logic       alu_ovf,
    input logic       rf_we,
    input logic [1:0] alu_op,
    input logic       mem_wr,
    input logic       ir_we,
    input logic [1:0] alu_b_sel,
    input logic       pc_we,
    input logic       pc_we_cond,
    input logic [1:0] pc_src,
    input logic       pc_load,
    input logic       epc_we,
    input logic       cause_we,
    input logic       cause_val
);
    // R1
    rst_quiet_chk: assert property (@(posedge clk)
        rst |-> !(rf_we || mem_wr || ir_we || pc_we || pc_we_cond || epc_we || cause_we));

    // R2
    fetch_to_decode_chk: assert property (@(posedge clk) disable iff (rst)
        ir_we |=> (!ir_we && alu_b_sel == 2'b11));

    // R7
    branch_zero_chk: assert property (@(posedge clk) disable iff (rst)
        pc_we_cond |-> (pc_load == alu_zero));

    // R9
    exc_redirect_chk: assert property (@(posedge clk) disable iff (rst)
        epc_we |-> (pc_we && pc_src == 2'b11 && cause_we));

    // R10
    ovf_trap_chk: assert property (@(posedge clk) disable iff (rst)
        (alu_op == 2'b10 && alu_ovf) |=> (cause_we && cause_val && !rf_we));

    // R11
    store_return_chk: assert property (@(posedge clk) disable iff (rst)
        mem_wr |=> ir_we);
endmodule

bind mc_ctrl_fsm mc_ctrl_fsm_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .alu_zero   (alu_zero),
    .alu_ovf    (alu_ovf),
    .rf_we      (rf_we),
    .alu_op     (alu_op),
    .mem_wr     (mem_wr),
    .ir_we      (ir_we),
    .alu_b_sel  (alu_b_sel),
    .pc_we      (pc_we),
    .pc_we_cond (pc_we_cond),
    .pc_src     (pc_src),
    .pc_load    (pc_load),
    .epc_we     (epc_we),
    .cause_we   (cause_we),
    .cause_val  (cause_val)
);

// File: tb/mc_ctrl_fsm_bench.sv
module mc_ctrl_fsm_bench;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [5:0] opcode = 6'd0;
    logic       alu_zero = 1'b0;
    logic       alu_ovf = 1'b0;
    logic       dst_sel_rd, rf_we, alu_a_sel, mem_rd, mem_wr, wb_sel_mem;
    logic       addr_sel_alu, ir_we, pc_we, pc_we_cond, pc_load;
    logic       epc_we, cause_we, cause_val;
    logic [1:0] alu_b_sel, alu_op, pc_src;

    int checks = 0;
    int errors = 0;
    int mstate = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mc_ctrl_fsm u_mc_ctrl_fsm (
        .clk(clk), .rst(rst), .opcode(opcode), .alu_zero(alu_zero), .alu_ovf(alu_ovf),
        .dst_sel_rd(dst_sel_rd), .rf_we(rf_we), .alu_a_sel(alu_a_sel), .alu_b_sel(alu_b_sel),
        .alu_op(alu_op), .mem_rd(mem_rd), .mem_wr(mem_wr), .wb_sel_mem(wb_sel_mem),
        .addr_sel_alu(addr_sel_alu), .ir_we(ir_we), .pc_we(pc_we), .pc_we_cond(pc_we_cond),
        .pc_src(pc_src), .pc_load(pc_load), .epc_we(epc_we), .cause_we(cause_we),
        .cause_val(cause_val)
    );

    function automatic logic [19:0] expect_ctl(int st, bit r, bit z);
        logic rd = 0, rw = 0, as = 0, mr = 0, mw = 0, wm = 0, ia = 0, ir = 0;
        logic pw = 0, pc = 0, ew = 0, cw = 0, cv = 0;
        logic [1:0] bs = 0, op = 0, ps = 0;
        if (r) return '0;
        case (st)
            0:  begin mr = 1; ir = 1; bs = 2'b01; pw = 1; end
            1:  bs = 2'b11;
            2:  begin as = 1; bs = 2'b10; end
            3:  begin mr = 1; ia = 1; end
            4:  begin rw = 1; wm = 1; end
            5:  begin mw = 1; ia = 1; end
            6:  begin as = 1; op = 2'b10; end
            7:  begin rw = 1; rd = 1; end
            8:  begin as = 1; op = 2'b01; pc = 1; ps = 2'b01; end
            9:  begin pw = 1; ps = 2'b10; end
            10, 11: begin bs = 2'b01; op = 2'b01; ew = 1; cw = 1; cv = (st == 11);
                          pw = 1; ps = 2'b11; end
            default: ;
        endcase
        return {rd, rw, as, bs, op, mr, mw, wm, ia, ir, pw, pc, ps, ew, cw, cv, pw | (pc & z)};
    endfunction

    // Reference next state; completion and exception states return to fetch (R11)
    function automatic int next_state(int st, logic [5:0] op, bit ov);
        case (st)
            0: return 1;
            1: begin
                if (op == 6'b100011 || op == 6'b101011) return 2;
                if (op == 6'b000000) return 6;
                if (op == 6'b000100) return 8;
                if (op == 6'b000010) return 9;
                return 10;
            end
            2: return (op == 6'b100011) ? 3 : 5;
            3: return 4;
            6: return ov ? 11 : 7;
            default: return 0;
        endcase
    endfunction

    function automatic string tag_of(int st, bit r);
        if (r) return "R1";
        case (st)
            0: return "R2/R11";
            1: return "R3";
            2, 3, 4: return "R4";
            5: return "R5";
            6, 7: return "R6";
            8: return "R7";
            9: return "R8";
            10: return "R9";
            default: return "R10";
        endcase
    endfunction

    task automatic step(bit r, logic [5:0] op, bit z, bit ov);
        logic [19:0] got, exp;
        @(negedge clk);
        rst = r; opcode = op; alu_zero = z; alu_ovf = ov;
        #1;
        got = {dst_sel_rd, rf_we, alu_a_sel, alu_b_sel, alu_op, mem_rd, mem_wr, wb_sel_mem,
               addr_sel_alu, ir_we, pc_we, pc_we_cond, pc_src, epc_we, cause_we, cause_val, pc_load};
        exp = expect_ctl(mstate, r, z);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s state %0d: got %b expected %b", tag_of(mstate, r), mstate, got, exp);
        end
        @(posedge clk);
        mstate = r ? 0 : next_state(mstate, op, ov);
    endtask

    task automatic run_instr(logic [5:0] op, bit z, bit ov);
        for (int i = 0; i < 8; i++) begin
            step(0, op, z, ov);
            if (mstate == 0) break;
        end
    endtask

    initial begin
        fork
            begin
                repeat (3) step(1, 6'b111111, 1, 1);          // R1 reset quiet
                run_instr(6'b100011, 1, 1);                   // R4 load, ovf/zero ignored (R10)
                run_instr(6'b101011, 1, 1);                   // R5 store
                run_instr(6'b000000, 1, 0);                   // R6 no overflow
                run_instr(6'b000000, 0, 1);                   // R10 overflow trap
                run_instr(6'b000100, 1, 1);                   // R7 branch taken
                run_instr(6'b000100, 0, 0);                   // R7 branch not taken
                run_instr(6'b000010, 1, 1);                   // R8 jump
                run_instr(6'b111111, 0, 0);                   // R9 undefined opcode
                run_instr(6'b000001, 1, 1);                   // R9 another undefined
                step(0, 6'b100011, 0, 0);
                step(0, 6'b100011, 0, 0);
                step(0, 6'b100011, 0, 0);
                step(1, 6'b100011, 1, 1);                     // R1 reset mid-load
                run_instr(6'b100011, 0, 0);                   // R1 restart at fetch
                run_instr(6'b000000, 0, 0);                   // R6 again
                done = 1;
            end
            begin
                repeat (100000) @(posedge clk);
                if (!done) begin
                    errors++;
                    checks++;
                    $display("FAIL watchdog: got hung expected finish");
                end
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule